// File: doc/BRIEF.md
# Fine-Grained Label Egress Port Filter

This block sits at the egress stage of a switch that carries frames tagged with a 24-bit fine-grained label. When such a frame has been decapsulated, the block decides which local ports may emit the native frame, what C-VLAN ID each of those ports puts on it, whether each port sends it untagged, and which priority and drop-eligible values the native frame carries. Each port holds a small set of accepted 24-bit labels, and each accepted label has its own C-VLAN ID. Port membership is decided only by the full label; VLAN configuration plays no part in it.

The selection logic covers three cases. A known-unicast frame goes to the learned ports. An unknown or unmatched unicast frame is flooded to every port that holds the label, except ports known not to reach the destination. A multi-destination frame is flooded to the member ports that the pruning mask allows. The address-learning and listener-pruning databases live outside the block and deliver their results as masks. If no port qualifies, the block reports a drop with a reason code instead of an empty forward. It also raises an onward-forward inhibit for multi-destination frames that arrived with the header multicast flag clear. Results are registered and appear one clock after the frame's inputs are presented.

The label tables are written through a configuration port. A slot write takes effect for frames presented from the next clock onward.

Top module: `fgl_egress_filter`

## Requirements
- R1: A port appears in `out_ports` only if one of its valid slots holds exactly the frame's 24-bit label; a port holding a label with the same upper 12 bits but different lower 12 bits is excluded, and invalidating a slot removes the port.
- R2: Lane p of `out_cvid` (bits p*12 +: 12) carries the C-VLAN ID stored with the lowest-numbered matching slot of port p when port p is in `out_ports`, and zero otherwise.
- R3: `out_pri` and `out_dei` equal the frame's low-word priority and drop-eligible inputs; the high-word priority and drop-eligible inputs have no effect on any output.
- R4: `out_untag[p]` is 1 exactly when port p is in `out_ports` and port p is configured to strip the tag.
- R5: A unicast frame (`in_md`=0) with `in_learn_hit`=1, whose learned mask overlaps the member ports other than the ingress port, goes to exactly that overlap.
- R6: Any other unicast frame is flooded to member ports that are not in `in_noreach` and are not the ingress port.
- R7: A multi-destination frame (`in_md`=1) goes to member ports allowed by `in_prune` (1 = allowed), excluding the ingress port.
- R8: `out_nofwd` is 1 exactly when `in_md`=1 and `in_mflag`=0, and local egress of such a frame still proceeds.
- R9: The ingress port `in_src` (a port index) never appears in `out_ports`.
- R10: When the selected mask is empty, `out_drop`=1, and `out_reason` is 1 if no port other than the ingress port holds the label, or 2 if member ports exist but the selection removes them all; otherwise `out_drop`=0 and `out_reason`=0.
- R11: After reset, and in any cycle following one with `in_vld`=0, `out_vld`, `out_ports`, `out_untag` and `out_drop` are 0; `out_vld` follows `in_vld` by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write one label slot |
| cfg_port | input | PW | Port index for a configuration write |
| cfg_slot | input | SW | Slot index for a slot write |
| cfg_valid | input | 1 | Slot valid bit to store |
| cfg_label | input | 24 | Label to store in the slot |
| cfg_cvid | input | 12 | C-VLAN ID for that label on that port |
| cfg_strip_we | input | 1 | Write the strip-tag option of cfg_port |
| cfg_strip | input | 1 | Strip-tag value to store |
| in_vld | input | 1 | Frame inputs are valid this cycle |
| in_label | input | 24 | Frame fine-grained label |
| in_hi_pri | input | 3 | High-word priority (transport only) |
| in_hi_dei | input | 1 | High-word drop-eligible bit |
| in_lo_pri | input | 3 | Low-word priority |
| in_lo_dei | input | 1 | Low-word drop-eligible bit |
| in_src | input | PW | Ingress port index |
| in_md | input | 1 | Inner destination is group, broadcast or unknown |
| in_mflag | input | 1 | Header multicast flag |
| in_learn_hit | input | 1 | Destination MAC found by address learning |
| in_learn_mask | input | NPORTS | Ports learned for the destination MAC |
| in_noreach | input | NPORTS | Ports known not to reach the destination MAC |
| in_prune | input | NPORTS | Ports allowed by multicast pruning |
| out_vld | output | 1 | Result valid |
| out_ports | output | NPORTS | Egress port mask |
| out_cvid | output | NPORTS*12 | Per-port C-VLAN ID lanes |
| out_untag | output | NPORTS | Per-port strip-tag indication |
| out_pri | output | 3 | Native frame priority |
| out_dei | output | 1 | Native frame drop-eligible bit |
| out_nofwd | output | 1 | Onward forwarding inhibited |
| out_drop | output | 1 | No port qualified |
| out_reason | output | 2 | Drop reason: 0 none, 1 no label holder, 2 filtered |

## Verification
The bench targets a port that shares only the upper half of the label. A design that compares only 12 bits would leak the frame there. It also covers a learned mask that misses every member port. A design that trusts the learned mask without falling back would drop a frame that should be flooded. It swaps distinct high-word and low-word priorities, which exposes a design that restores the transport priority. Further cases cover the ingress port as the only remaining member, a frame that pruning empties, and a slot that is invalidated after use. In these cases a faulty design would echo the frame back, give the wrong drop reason, or keep sending to a port whose label was removed.

// File: rtl/fgl_pkg.sv
package fgl_pkg;
  localparam int LABEL_W = 24;
  localparam int CVID_W  = 12;

  typedef enum logic [1:0] {
    DROP_NONE     = 2'd0,
    DROP_NOLABEL  = 2'd1,
    DROP_FILTERED = 2'd2
  } drop_e;
endpackage

// File: rtl/fgl_label_table.sv
module fgl_label_table #(
  parameter int SLOTS = 4,
  parameter int LBL_W = 24,
  parameter int VID_W = 12,
  localparam int SW = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [SW-1:0]    wr_slot,
  input  logic             wr_valid,
  input  logic [LBL_W-1:0] wr_label,
  input  logic [VID_W-1:0] wr_cvid,
  input  logic             strip_we,
  input  logic             strip_val,
  input  logic [LBL_W-1:0] look_label,
  output logic             hit,
  output logic [VID_W-1:0] hit_cvid,
  output logic             strip
);
  logic [SLOTS-1:0] slot_ok;
  logic [LBL_W-1:0] slot_lbl [SLOTS];
  logic [VID_W-1:0] slot_vid [SLOTS];
  logic             strip_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_ok <= '0;
      strip_q <= 1'b0;
    end else begin
      if (wr_en) slot_ok[wr_slot] <= wr_valid;
      if (strip_we) strip_q <= strip_val;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      slot_lbl[wr_slot] <= wr_label;
      slot_vid[wr_slot] <= wr_cvid;
    end
  end

  logic [SLOTS-1:0] match;
  genvar s;
  generate
    for (s = 0; s < SLOTS; s++) begin : g_cmp
      assign match[s] = slot_ok[s] && (slot_lbl[s] == look_label);
    end
  endgenerate

  always_comb begin
    hit_cvid = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (match[i]) hit_cvid = slot_vid[i];
    end
  end

  assign hit   = |match;
  assign strip = strip_q;
endmodule

// File: rtl/fgl_port_select.sv
module fgl_port_select
  import fgl_pkg::*;
#(
  parameter int NPORTS = 4
) (
  input  logic [NPORTS-1:0] member,
  input  logic [NPORTS-1:0] src_hot,
  input  logic              md,
  input  logic              learn_hit,
  input  logic [NPORTS-1:0] learn_mask,
  input  logic [NPORTS-1:0] noreach,
  input  logic [NPORTS-1:0] prune,
  output logic [NPORTS-1:0] sel,
  output drop_e             reason
);
  logic [NPORTS-1:0] cand;
  logic [NPORTS-1:0] known;
  logic [NPORTS-1:0] flood;
  logic [NPORTS-1:0] mdest;

  assign cand  = member & ~src_hot;
  assign known = cand & learn_mask;
  assign flood = cand & ~noreach;
  assign mdest = cand & prune;

  always_comb begin
    if (md)                         sel = mdest;
    else if (learn_hit && |known)   sel = known;
    else                            sel = flood;

    if (|sel)       reason = DROP_NONE;
    else if (|cand) reason = DROP_FILTERED;
    else            reason = DROP_NOLABEL;
  end
endmodule

// File: rtl/fgl_egress_filter.sv
module fgl_egress_filter
  import fgl_pkg::*;
#(
  parameter int NPORTS = 4,
  parameter int SLOTS  = 4,
  parameter int LBL_W  = LABEL_W,
  parameter int VID_W  = CVID_W,
  localparam int PW = (NPORTS > 1) ? $clog2(NPORTS) : 1,
  localparam int SW = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cfg_we,
  input  logic [PW-1:0]           cfg_port,
  input  logic [SW-1:0]           cfg_slot,
  input  logic                    cfg_valid,
  input  logic [LBL_W-1:0]        cfg_label,
  input  logic [VID_W-1:0]        cfg_cvid,
  input  logic                    cfg_strip_we,
  input  logic                    cfg_strip,
  input  logic                    in_vld,
  input  logic [LBL_W-1:0]        in_label,
  input  logic [2:0]              in_hi_pri,
  input  logic                    in_hi_dei,
  input  logic [2:0]              in_lo_pri,
  input  logic                    in_lo_dei,
  input  logic [PW-1:0]           in_src,
  input  logic                    in_md,
  input  logic                    in_mflag,
  input  logic                    in_learn_hit,
  input  logic [NPORTS-1:0]       in_learn_mask,
  input  logic [NPORTS-1:0]       in_noreach,
  input  logic [NPORTS-1:0]       in_prune,
  output logic                    out_vld,
  output logic [NPORTS-1:0]       out_ports,
  output logic [NPORTS*VID_W-1:0] out_cvid,
  output logic [NPORTS-1:0]       out_untag,
  output logic [2:0]              out_pri,
  output logic                    out_dei,
  output logic                    out_nofwd,
  output logic                    out_drop,
  output logic [1:0]              out_reason
);
  logic [NPORTS-1:0]       member;
  logic [NPORTS-1:0]       strip_cfg;
  logic [NPORTS*VID_W-1:0] lane_vid;
  logic [NPORTS-1:0]       src_hot;

  genvar p;
  generate
    for (p = 0; p < NPORTS; p++) begin : g_port
      logic sel_wr;
      logic sel_strip;
      assign sel_wr    = cfg_we && (cfg_port == PW'(p));
      assign sel_strip = cfg_strip_we && (cfg_port == PW'(p));
      assign src_hot[p] = (in_src == PW'(p));

      fgl_label_table #(
        .SLOTS(SLOTS), .LBL_W(LBL_W), .VID_W(VID_W)
      ) u_tbl (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (sel_wr),
        .wr_slot   (cfg_slot),
        .wr_valid  (cfg_valid),
        .wr_label  (cfg_label),
        .wr_cvid   (cfg_cvid),
        .strip_we  (sel_strip),
        .strip_val (cfg_strip),
        .look_label(in_label),
        .hit       (member[p]),
        .hit_cvid  (lane_vid[p*VID_W +: VID_W]),
        .strip     (strip_cfg[p])
      );
    end
  endgenerate

  logic [NPORTS-1:0] sel;
  drop_e             reason;

  fgl_port_select #(.NPORTS(NPORTS)) u_sel (
    .member    (member),
    .src_hot   (src_hot),
    .md        (in_md),
    .learn_hit (in_learn_hit),
    .learn_mask(in_learn_mask),
    .noreach   (in_noreach),
    .prune     (in_prune),
    .sel       (sel),
    .reason    (reason)
  );

  logic [NPORTS*VID_W-1:0] vid_gated;
  always_comb begin
    for (int i = 0; i < NPORTS; i++) begin
      vid_gated[i*VID_W +: VID_W] = sel[i] ? lane_vid[i*VID_W +: VID_W] : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld    <= 1'b0;
      out_ports  <= '0;
      out_cvid   <= '0;
      out_untag  <= '0;
      out_pri    <= '0;
      out_dei    <= 1'b0;
      out_nofwd  <= 1'b0;
      out_drop   <= 1'b0;
      out_reason <= DROP_NONE;
    end else if (in_vld) begin
      out_vld    <= 1'b1;
      out_ports  <= sel;
      out_cvid   <= vid_gated;
      out_untag  <= sel & strip_cfg;
      out_pri    <= in_lo_pri;
      out_dei    <= in_lo_dei;
      out_nofwd  <= in_md && !in_mflag;
      out_drop   <= ~|sel;
      out_reason <= reason;
    end else begin
      out_vld    <= 1'b0;
      out_ports  <= '0;
      out_cvid   <= '0;
      out_untag  <= '0;
      out_pri    <= '0;
      out_dei    <= 1'b0;
      out_nofwd  <= 1'b0;
      out_drop   <= 1'b0;
      out_reason <= DROP_NONE;
    end
  end
endmodule

// File: rtl/fgl_egress_chk.sv
module fgl_egress_chk #(
  parameter int NPORTS = 4,
  parameter int SLOTS  = 4,
  parameter int LBL_W  = 24,
  parameter int VID_W  = 12,
  localparam int PW = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input logic              clk,
  input logic              rst,
  input logic              in_vld,
  input logic [2:0]        in_lo_pri,
  input logic              in_lo_dei,
  input logic [PW-1:0]     in_src,
  input logic              in_md,
  input logic              in_mflag,
  input logic [NPORTS-1:0] in_prune,
  input logic              out_vld,
  input logic [NPORTS-1:0] out_ports,
  input logic [NPORTS-1:0] out_untag,
  input logic [2:0]        out_pri,
  input logic              out_dei,
  input logic              out_nofwd,
  input logic              out_drop,
  input logic [1:0]        out_reason
);
  a_r11_vld_follows: assert property (@(posedge clk) disable iff (rst)
    out_vld == $past(in_vld));

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !out_vld |-> (out_ports == '0 && out_untag == '0 && !out_drop));

  a_r9_src_excluded: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> !out_ports[$past(in_src)]);

  a_r3_low_word_pri: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> (out_pri == $past(in_lo_pri) && out_dei == $past(in_lo_dei)));

  a_r8_nofwd: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> (out_nofwd == ($past(in_md) && !$past(in_mflag))));

  a_r7_pruned: assert property (@(posedge clk) disable iff (rst)
    (out_vld && $past(in_md)) |-> ((out_ports & ~$past(in_prune)) == '0));

  a_r4_untag_subset: assert property (@(posedge clk) disable iff (rst)
    (out_untag & ~out_ports) == '0);

  a_r10_drop_empty: assert property (@(posedge clk) disable iff (rst)
    (out_vld && out_drop) |-> (out_ports == '0 && out_reason != 2'd0));

  a_r10_fwd_nonempty: assert property (@(posedge clk) disable iff (rst)
    (out_vld && !out_drop) |-> (out_ports != '0 && out_reason == 2'd0));
endmodule

bind fgl_egress_filter fgl_egress_chk #(
  .NPORTS(NPORTS), .SLOTS(SLOTS), .LBL_W(LBL_W), .VID_W(VID_W)
) u_chk (.*);

// File: tb/sim_fgl_egress_filter.sv
`timescale 1ns/1ps
module sim_fgl_egress_filter;
  localparam int NP = 4;
  localparam int NS = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic        cfg_we = 0, cfg_valid = 0, cfg_strip_we = 0, cfg_strip = 0;
  logic [1:0]  cfg_port = 0, cfg_slot = 0;
  logic [23:0] cfg_label = 0;
  logic [11:0] cfg_cvid = 0;
  logic        in_vld = 0, in_hi_dei = 0, in_lo_dei = 0, in_md = 0, in_mflag = 0, in_learn_hit = 0;
  logic [23:0] in_label = 0;
  logic [2:0]  in_hi_pri = 0, in_lo_pri = 0;
  logic [1:0]  in_src = 0;
  logic [3:0]  in_learn_mask = 0, in_noreach = 0, in_prune = 0;
  logic        out_vld, out_dei, out_nofwd, out_drop;
  logic [3:0]  out_ports, out_untag;
  logic [47:0] out_cvid;
  logic [2:0]  out_pri;
  logic [1:0]  out_reason;

  fgl_egress_filter #(.NPORTS(NP), .SLOTS(NS)) u0 (.*);

  int checks = 0;
  int errors = 0;

  localparam logic [23:0] LA = 24'h123456;
  localparam logic [23:0] LB = 24'h123457;
  localparam logic [23:0] LC = 24'h123999;
  localparam logic [23:0] LZ = 24'hABCDEF;

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  task automatic wr_slot(input logic [1:0] p, input logic [1:0] s, input logic v,
                         input logic [23:0] l, input logic [11:0] c);
    @(negedge clk);
    cfg_we = 1; cfg_port = p; cfg_slot = s; cfg_valid = v; cfg_label = l; cfg_cvid = c;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic wr_strip(input logic [1:0] p, input logic v);
    @(negedge clk);
    cfg_strip_we = 1; cfg_port = p; cfg_strip = v;
    @(negedge clk);
    cfg_strip_we = 0;
  endtask

  // drive one frame, leave outputs ready to sample one negedge later
  task automatic send(input logic [23:0] l, input logic [1:0] src, input logic md,
                      input logic mf, input logic hit, input logic [3:0] lm,
                      input logic [3:0] nr, input logic [3:0] pr);
    @(negedge clk);
    in_vld = 1; in_label = l; in_src = src; in_md = md; in_mflag = mf;
    in_learn_hit = hit; in_learn_mask = lm; in_noreach = nr; in_prune = pr;
    @(negedge clk);
    in_vld = 0;
  endtask

  task automatic t_reset();
    chk("R11 reset vld", 64'(out_vld), 64'd0);
    chk("R11 reset ports", 64'(out_ports), 64'd0);
  endtask

  task automatic t_membership();
    send(LA, 2'd3, 0, 0, 0, 4'b0000, 4'b0000, 4'b0000);
    chk("R1 full label members", 64'(out_ports), 64'b0111);
    chk("R6 flood no drop", 64'(out_drop), 64'd0);
    send(LC, 2'd0, 0, 0, 0, 4'b0000, 4'b0000, 4'b0000);
    chk("R1 upper-half twin only", 64'(out_ports), 64'b1000);
  endtask

  task automatic t_cvid_strip();
    send(LA, 2'd3, 0, 0, 0, 4'b0000, 4'b0000, 4'b0000);
    chk("R2 cvid lanes", 64'(out_cvid), {12'h000, 12'h032, 12'h020, 12'h010});
    chk("R4 untag", 64'(out_untag), 64'b0010);
  endtask

  task automatic t_priority();
    @(negedge clk);
    in_hi_pri = 3'd7; in_hi_dei = 1; in_lo_pri = 3'd2; in_lo_dei = 0;
    send(LA, 2'd3, 0, 0, 0, 4'b0000, 4'b0000, 4'b0000);
    chk("R3 pri from low word", 64'(out_pri), 64'd2);
    chk("R3 dei from low word", 64'(out_dei), 64'd0);
    @(negedge clk);
    in_hi_pri = 3'd1; in_hi_dei = 0; in_lo_pri = 3'd5; in_lo_dei = 1;
    send(LA, 2'd3, 0, 0, 0, 4'b0000, 4'b0000, 4'b0000);
    chk("R3 pri swap", 64'({out_pri, out_dei}), 64'({3'd5, 1'b1}));
    chk("R3 high word no effect on ports", 64'(out_ports), 64'b0111);
  endtask

  task automatic t_unicast();
    send(LA, 2'd0, 0, 0, 1, 4'b0100, 4'b0000, 4'b0000);
    chk("R5 known unicast", 64'(out_ports), 64'b0100);
    send(LA, 2'd0, 0, 0, 1, 4'b1000, 4'b0010, 4'b0000);
    chk("R6 fallback flood minus noreach", 64'(out_ports), 64'b0100);
    send(LA, 2'd3, 0, 0, 0, 4'b0000, 4'b0101, 4'b0000);
    chk("R6 unknown flood minus noreach", 64'(out_ports), 64'b0010);
  endtask

  task automatic t_multidest();
    send(LA, 2'd1, 1, 1, 0, 4'b0000, 4'b1111, 4'b0011);
    chk("R7 pruned flood", 64'(out_ports), 64'b0001);
    chk("R8 nofwd clear with mflag", 64'(out_nofwd), 64'd0);
    send(LB, 2'd0, 1, 0, 0, 4'b0000, 4'b0000, 4'b1111);
    chk("R8 local egress proceeds", 64'(out_ports), 64'b0110);
    chk("R8 nofwd set", 64'(out_nofwd), 64'd1);
  endtask

  task automatic t_source();
    send(LB, 2'd1, 0, 0, 0, 4'b0000, 4'b0000, 4'b0000);
    chk("R9 ingress excluded", 64'(out_ports), 64'b0100);
  endtask

  task automatic t_drop();
    send(LZ, 2'd0, 0, 0, 0, 4'b0000, 4'b0000, 4'b1111);
    chk("R10 unknown label drop", 64'({out_drop, out_reason, out_ports}), 64'({1'b1, 2'd1, 4'b0000}));
    send(LC, 2'd3, 0, 0, 0, 4'b0000, 4'b0000, 4'b0000);
    chk("R10 only ingress holds", 64'({out_drop, out_reason}), 64'({1'b1, 2'd1}));
    send(LB, 2'd2, 1, 1, 0, 4'b0000, 4'b0000, 4'b0100);
    chk("R10 filtered by prune", 64'({out_drop, out_reason, out_ports}), 64'({1'b1, 2'd2, 4'b0000}));
  endtask

  task automatic t_invalidate();
    wr_slot(2'd3, 2'd0, 1'b0, LC, 12'h040);
    send(LC, 2'd0, 0, 0, 0, 4'b0000, 4'b0000, 4'b0000);
    chk("R1 invalidated slot", 64'({out_drop, out_reason, out_ports}), 64'({1'b1, 2'd1, 4'b0000}));
  endtask

  task automatic t_idle();
    @(negedge clk);
    chk("R11 idle vld", 64'(out_vld), 64'd0);
    chk("R11 idle ports", 64'({out_ports, out_untag, out_drop}), 64'd0);
  endtask

  initial begin
    #2000000;
    checks++; errors++;
    $display("FAIL R11 watchdog actual=timeout expected=done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    wr_slot(2'd0, 2'd0, 1'b1, LA, 12'h010);
    wr_slot(2'd1, 2'd0, 1'b1, LA, 12'h020);
    wr_slot(2'd1, 2'd1, 1'b1, LB, 12'h021);
    wr_slot(2'd2, 2'd0, 1'b1, LB, 12'h030);
    wr_slot(2'd2, 2'd2, 1'b1, LA, 12'h032);
    wr_slot(2'd3, 2'd0, 1'b1, LC, 12'h040);
    wr_strip(2'd1, 1'b1);
    t_membership();
    t_cvid_strip();
    t_priority();
    t_unicast();
    t_multidest();
    t_source();
    t_drop();
    t_invalidate();
    t_idle();
    summary();
    $finish;
  end
endmodule